// File: doc/BRIEF.md
# Low-Power Seconds Counter with One-Shot Alarm

This block is a real-time-clock peripheral behind a plain 32-bit register port. A 47-bit counter advances once per slow tick, and the slow tick is made by dividing the bus clock by `CLK_DIV`. The low 15 bits of the counter count fractions of a second. The upper 32 bits hold whole seconds. Software reads the counter through two registers. It can load the counter only while counting is stopped. A run request passes through a small state machine that moves only on slow ticks, and software polls the read-back copy of that state. The read-back copy is the effective enable.

A seconds alarm compares the seconds field with a 32-bit alarm register. On a match it sets a sticky status flag, and software clears that flag by writing one to it. The interrupt/wakeup output is a level signal. It is high while the flag is set, alarm checking is enabled and wakeup is enabled.

The run-enable state machine has four states. `ST_STOPPED` moves to `ST_STARTING` on a tick when the run request is 1. `ST_STARTING` moves to `ST_RUNNING` on the next tick if the request is still 1, and returns to `ST_STOPPED` if it is not. `ST_RUNNING` moves to `ST_STOPPING` on a tick when the request is 0. `ST_STOPPING` moves to `ST_STOPPED` on the next tick if the request is still 0, and returns to `ST_RUNNING` if it is not. The counter is enabled in `ST_RUNNING` and in `ST_STOPPING`.

Top module: `lp_rtc`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. This covers offsets 0x04, 0x18, 0x1C, 0x20, 0x24, 0x30 and any unused address.
- R2: A slow tick occurs once every `CLK_DIV` bus clocks. While the effective enable is 1, the 47-bit counter advances by exactly one on each tick.
- R3: Bit 0 of control (0x04) is the run request when written. When read, it returns the effective enable. A changed request becomes visible in the read-back just after the second tick that follows the write, counting only ticks strictly after the write edge. Until then the counter behaves as before.
- R4: Offset 0x20 reads counter bits 31..0. Offset 0x1C reads counter bits 46..32 in its bits 14..0, with zeros above them. Seconds are counter bits 46..15.
- R5: Writes to 0x1C and 0x20 load the counter only while the effective enable reads 0. While it reads 1, these writes are ignored and counting continues.
- R6: Status bit 0 (0x18) sets on the clock after the seconds field equals the alarm register (0x24) while control bit 1 (alarm enable) is 1. Once set, it stays set until it is cleared.
- R7: Writing a 1 to status bit 0 clears the flag, so writing all ones clears it too. Writing 0 has no effect. If a match occurs in the same cycle as a clear, the set takes priority.
- R8: Writes to the alarm register are ignored while control bit 1 is 1.
- R9: `irq` = status bit 0 AND control bit 1 AND control bit 3 (wakeup enable). It is a level signal that follows these three bits.
- R10: Control bits 1 and 3 read back as written. Every other control bit reads 0, except bit 0, which reads as in R3. Offset 0x30 is a glitch-detect word that stores and returns all 32 bits.
- R11: The counter wraps from 2^47-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also divided down to make the slow tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset, used for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt/wakeup level |

## Verification
The embedded properties check, on every cycle, that:
- ticks never occur on two cycles in a row;
- the effective enable changes only on the clock after a tick;
- the counter either steps by exactly one on an enabled tick or holds (writes aside);
- the alarm flag is sticky unless a clear is written;
- the alarm register is locked while alarm checking is on.

Some behaviours need the bench's scenarios instead:
- the exact tick on which the enable read-back changes;
- the exact cycle at which a run of sub-second ticks carries into a match;
- set-over-clear priority;
- the layout of the counter halves and their wrap;
- the combinations of flag and enable bits that decide `irq`.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
    localparam int CNT_W  = 47;
    localparam int SUB_W  = 15;
    localparam int WORD_W = 32;

    localparam logic [7:0] OFF_CTRL  = 8'h04;
    localparam logic [7:0] OFF_STAT  = 8'h18;
    localparam logic [7:0] OFF_CNTHI = 8'h1C;
    localparam logic [7:0] OFF_CNTLO = 8'h20;
    localparam logic [7:0] OFF_ALARM = 8'h24;
    localparam logic [7:0] OFF_GLTCH = 8'h30;

    localparam int BIT_RUN  = 0;
    localparam int BIT_ALM  = 1;
    localparam int BIT_WAKE = 3;

    typedef enum logic [1:0] {
        ST_STOPPED,
        ST_STARTING,
        ST_RUNNING,
        ST_STOPPING
    } run_state_t;
endpackage

// File: rtl/lp_rtc_tick.sv
module lp_rtc_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                 pre <= pre + 1'b1;
    end

    assign tick = (pre == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/lp_rtc_ensync.sv
module lp_rtc_ensync
    import lp_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run_req,
    output logic eff_en
);
    run_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (tick) begin
            unique case (state)
                ST_STOPPED:  if (run_req)  state_nx = ST_STARTING;
                ST_STARTING: state_nx = run_req ? ST_RUNNING : ST_STOPPED;
                ST_RUNNING:  if (!run_req) state_nx = ST_STOPPING;
                ST_STOPPING: state_nx = run_req ? ST_RUNNING : ST_STOPPED;
                default:     state_nx = ST_STOPPED;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_RUNNING, ST_STOPPING: eff_en = 1'b1;
            default:                 eff_en = 1'b0;
        endcase
    end

    AST_EN_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(eff_en)); // R3
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter
    import lp_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    localparam int HI_W = CNT_W - WORD_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            if (tick) count <= count + CNT_W'(1);
        end else begin
            if (ld_lo) count[WORD_W-1:0] <= wdata;
            if (ld_hi) count[CNT_W-1:WORD_W] <= wdata[HI_W-1:0];
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && run) |-> count == $past(count) + CNT_W'(1)); // R2
    AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick && run) && !$past(!run && (ld_lo || ld_hi))) |-> $stable(count)); // R5
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
    import lp_rtc_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int HI_W = CNT_W - WORD_W;

    logic              tick, eff_en;
    logic              ctl_run, ctl_alm, ctl_wake;
    logic              alm_flag, sec_match, stat_clr;
    logic [WORD_W-1:0] alarm_sec, glitch_word;
    logic [CNT_W-1:0]  count;
    logic              wr_ctrl, wr_stat, wr_hi, wr_lo, wr_alarm, wr_glt;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
    assign wr_hi    = bus_wr && (bus_addr == ADDR_W'(OFF_CNTHI));
    assign wr_lo    = bus_wr && (bus_addr == ADDR_W'(OFF_CNTLO));
    assign wr_alarm = bus_wr && (bus_addr == ADDR_W'(OFF_ALARM));
    assign wr_glt   = bus_wr && (bus_addr == ADDR_W'(OFF_GLTCH));

    lp_rtc_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    lp_rtc_ensync u_sync (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_req(ctl_run), .eff_en(eff_en)
    );

    lp_rtc_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(eff_en),
        .ld_lo(wr_lo), .ld_hi(wr_hi), .wdata(bus_wdata), .count(count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_run     <= 1'b0;
            ctl_alm     <= 1'b0;
            ctl_wake    <= 1'b0;
            alarm_sec   <= '0;
            glitch_word <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl_run  <= bus_wdata[BIT_RUN];
                ctl_alm  <= bus_wdata[BIT_ALM];
                ctl_wake <= bus_wdata[BIT_WAKE];
            end
            if (wr_alarm && !ctl_alm) alarm_sec <= bus_wdata;
            if (wr_glt) glitch_word <= bus_wdata;
        end
    end

    assign sec_match = ctl_alm && (count[CNT_W-1:SUB_W] == alarm_sec);
    assign stat_clr  = wr_stat && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         alm_flag <= 1'b0;
        else if (sec_match) alm_flag <= 1'b1;
        else if (stat_clr)  alm_flag <= 1'b0;
    end

    assign irq = alm_flag && ctl_alm && ctl_wake;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            bus_rdata[BIT_RUN]  = eff_en;
            bus_rdata[BIT_ALM]  = ctl_alm;
            bus_rdata[BIT_WAKE] = ctl_wake;
        end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
            bus_rdata[0] = alm_flag;
        end else if (bus_addr == ADDR_W'(OFF_CNTHI)) begin
            bus_rdata[HI_W-1:0] = count[CNT_W-1:WORD_W];
        end else if (bus_addr == ADDR_W'(OFF_CNTLO)) begin
            bus_rdata = count[WORD_W-1:0];
        end else if (bus_addr == ADDR_W'(OFF_ALARM)) begin
            bus_rdata = alarm_sec;
        end else if (bus_addr == ADDR_W'(OFF_GLTCH)) begin
            bus_rdata = glitch_word;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alm_flag) && !$past(stat_clr)) |-> alm_flag); // R6
    AST_ALARM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_alm) |-> $stable(alarm_sec)); // R8
    AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wake |-> !irq); // R9
endmodule

// File: tb/lp_rtc_bench.sv
module lp_rtc_bench;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    lp_rtc #(.CLK_DIV(DIV), .ADDR_W(8)) u_lp_rtc (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_run(input bit want, output int at);
        logic [31:0] v;
        at = -1;
        for (int i = 0; i < 200; i++) begin
            rd(8'h04, v);
            if (v[0] == want) begin
                at = ecnt;
                return;
            end
            @(negedge clk);
        end
    endtask

    function automatic int expect_sync(input int e_w);
        return (e_w / DIV + 1) * DIV + DIV;
    endfunction

    function automatic int ticks_in(input int a, input int b);
        return b / DIV - a / DIV;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, x, s;
        logic [46:0] cv;
        int at, a, b, e_w;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        foreach (v[i]) ; // no-op placeholder loop free
        rd(8'h04, v); check("R1 ctrl", v, 0);
        rd(8'h18, v); check("R1 stat", v, 0);
        rd(8'h1C, v); check("R1 hi", v, 0);
        rd(8'h20, v); check("R1 lo", v, 0);
        rd(8'h24, v); check("R1 alarm", v, 0);
        rd(8'h30, v); check("R1 glitch", v, 0);
        rd(8'h00, v); check("R1 unused", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R10 glitch word and control read-back
        x = $urandom;
        wr(8'h30, x); rd(8'h30, v); check("R10 glitch", v, x);
        wr(8'h24, 32'd5);
        wr(8'h04, 32'hFFFF_FFF6); rd(8'h04, v); check("R10 ctrl bits", v, 32'h2);
        wr(8'h04, 32'h0000_000A); rd(8'h04, v); check("R10 ctrl alm+wake", v, 32'hA);
        wr(8'h04, 32'h0); rd(8'h04, v); check("R10 ctrl clear", v, 0);

        // R4 counter layout
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); check("R4 hi width", v, 32'h7FFF);
        x = $urandom;
        wr(8'h20, x); rd(8'h20, v); check("R5 load while stopped", v, x);

        // R11 wrap, R3 start timing
        wr(8'h1C, 32'h7FFF); wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h04, 32'h1); e_w = ecnt;
        wait_run(1'b1, at);
        check("R3 start edge", at, expect_sync(e_w));
        rd(8'h1C, v); check("R3 no count before run hi", v, 32'h7FFF);
        rd(8'h20, v); check("R3 no count before run lo", v, 32'hFFFF_FFFF);
        repeat (DIV) @(negedge clk);
        rd(8'h1C, v); check("R11 wrap hi", v, 0);
        rd(8'h20, v); check("R11 wrap lo", v, 0);

        // R2 rate under random waits
        for (int k = 0; k < 6; k++) begin
            int w;
            w = 1 + ($urandom % (6 * DIV));
            rd(8'h20, x); a = ecnt;
            repeat (w) @(negedge clk);
            rd(8'h20, v); b = ecnt;
            check("R2 tick rate", v, x + ticks_in(a, b));
        end

        // R5 writes ignored while running
        rd(8'h20, x); a = ecnt;
        wr(8'h20, 32'h1234_5678);
        wr(8'h1C, 32'h1);
        rd(8'h20, v); b = ecnt;
        check("R5 lo ignored", v, x + ticks_in(a, b));
        rd(8'h1C, v); check("R5 hi ignored", v, 0);

        // R3 stop timing and freeze
        wr(8'h04, 32'h0); e_w = ecnt;
        wait_run(1'b0, at);
        check("R3 stop edge", at, expect_sync(e_w));
        rd(8'h20, x);
        repeat (3 * DIV) @(negedge clk);
        rd(8'h20, v); check("R3 frozen when stopped", v, x);

        // R6 exact match timing, R9 irq
        s = 32'h0000_1234;
        cv = {s, 15'd0} - 47'd16;
        wr(8'h1C, {17'd0, cv[46:32]}); wr(8'h20, cv[31:0]);
        wr(8'h24, s);
        wr(8'h04, 32'hB); e_w = ecnt;
        rd(8'h18, v); check("R6 no early flag", v, 0);
        at = -1;
        for (int i = 0; i < 400; i++) begin
            rd(8'h18, v);
            if (v[0]) begin at = ecnt; break; end
            @(negedge clk);
        end
        check("R6 match edge", at, expect_sync(e_w) + 16 * DIV + 1);
        check("R9 irq high", {31'b0, irq}, 1);

        // R8 alarm locked while armed
        wr(8'h24, 32'hABCD); rd(8'h24, v); check("R8 alarm locked", v, s);

        // R7 clear behaviour
        wr(8'h18, 32'h1); rd(8'h18, v); check("R7 set beats clear", v, 1);
        wr(8'h04, 32'h9); rd(8'h18, v); check("R6 sticky after disarm", v, 1);
        check("R9 irq off without alarm enable", {31'b0, irq}, 0);
        wr(8'h18, 32'h0); rd(8'h18, v); check("R7 zero write no effect", v, 1);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); check("R7 all ones clears", v, 0);
        wr(8'h24, 32'hABCD); rd(8'h24, v); check("R8 alarm writable when disarmed", v, 32'hABCD);

        wr(8'h04, 32'h0);
        wait_run(1'b0, at);
        check("R3 stopped again", at >= 0, 1);

        // R6/R9 constrained random
        for (int k = 0; k < 16; k++) begin
            bit hit, aen, wke;
            logic [31:0] alm;
            logic [46:0] c2;
            s   = $urandom;
            hit = $urandom % 2;
            aen = $urandom % 2;
            wke = $urandom % 2;
            alm = hit ? s : s + 32'd1;
            c2  = {s, 15'd0};
            wr(8'h1C, {17'd0, c2[46:32]}); wr(8'h20, c2[31:0]);
            wr(8'h24, alm);
            wr(8'h04, {28'd0, wke, 1'b0, aen, 1'b0});
            @(negedge clk);
            rd(8'h18, v); check("R6 random match", v, {31'b0, hit & aen});
            check("R9 random irq", {31'b0, irq}, {31'b0, hit & aen & wke});
            wr(8'h04, 32'h0);
            wr(8'h18, 32'hFFFF_FFFF);
            rd(8'h18, v); check("R7 random clear", v, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule